// File: doc/BRIEF.md
# Jam-Loaded Serial-Out Shift Register

This block is an eight-stage shift register. It takes data either one bit at a time through a serial input or as a whole byte through eight jam inputs. It sends the data out serially from the last stage. A single mode input selects the operation. When the mode input is low, the register shifts on each rising clock edge. When it is high, the register loads the jam inputs.

A compile-time parameter chooses how the load behaves:

- **Edge-captured variant:** the load is taken on the rising clock edge.
- **Level-sensitive variant:** the load is asynchronous. While the mode input is high, each stage is forced to its jam bit through a per-bit asynchronous set or clear, with no clock edge needed.

Besides the last stage, the register brings out stages 6 and 7 as taps. Instances can be chained into longer registers by feeding one instance's serial output into the next instance's serial input.

There is no reset. The contents are undefined at power-up until a load has been done or eight shifts have filled the register.

The mode decoder has two named operations:

- **OP_SHIFT:** mode input low. A rising edge moves each stage one place toward the output.
- **OP_LOAD:** mode input high. The jam inputs are written into the stages, either on the edge or at once, depending on the variant.

The two transitions are:

- **shift→load:** the mode input rises.
- **load→shift:** the mode input falls.

Top module: `jam_shift_reg`

## Requirements
- R1: With load_ctrl low, each rising clk edge writes ser_in into stage 1 and moves the content of stage n into stage n+1, for n from 1 to 7.
- R2: In the edge-captured variant (ASYNC_LOAD=0), a rising edge with load_ctrl high writes par_in[i] into stage i+1. par_in[0] is stage 1, next to the serial input, and par_in[7] is stage 8.
- R3: In the level-sensitive variant (ASYNC_LOAD=1), while load_ctrl is high, every stage follows its par_in bit without any clock edge, including changes of par_in within a clock period.
- R4: After a load, ser_out presents par_in[7] first. Each following shift edge presents the next lower jam bit, down to par_in[0] after seven shifts.
- R5: tap_lo shows stage 6, tap_mid shows stage 7 and ser_out shows stage 8 at all times.
- R6: When there is no rising clk edge and no level-sensitive load is active, no stage changes, whatever ser_in and par_in do.
- R7: Two instances chained from ser_out to ser_in behave as one 16-stage register. The upstream stage 8 enters the downstream stage 1 on each shift edge.
- R8: In the level-sensitive variant, the first rising edge after load_ctrl falls performs a normal shift of the loaded data.
- R9: During a load, ser_in has no effect on any stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; the register acts on its rising edge |
| load_ctrl | input | 1 | High selects the load operation, low selects the shift operation |
| ser_in | input | 1 | Serial data entering stage 1 |
| par_in | input | STAGES (8) | Jam inputs; bit i goes to stage i+1 |
| tap_lo | output | 1 | Content of stage 6 |
| tap_mid | output | 1 | Content of stage 7 |
| ser_out | output | 1 | Content of stage 8; this is the chaining output |

## Verification
The hardest situation to reach from the ports is a change of the jam inputs between two clock edges while the level-sensitive load is held. The stages must follow that change, and the edge-captured instance next to it must stay unchanged. The bench drives load_ctrl and par_in just after the falling edge, then inverts par_in again a few nanoseconds later. It samples both instances before the next rising edge, so the asynchronous path and the hold behaviour are each seen within one clock period. The release edge after a held load is checked separately against the queue model. So is the carry of bits across the chained pair.

// File: rtl/jsr_pkg.sv
package jsr_pkg;

    typedef enum logic {
        OP_SHIFT = 1'b0,
        OP_LOAD  = 1'b1
    } op_e;

endpackage

// File: rtl/jsr_mode_decode.sv
module jsr_mode_decode
    import jsr_pkg::*;
(
    input  logic load_ctrl,
    output op_e  op
);

    always_comb begin
        unique case (load_ctrl)
            1'b1:    op = OP_LOAD;
            default: op = OP_SHIFT;
        endcase
    end

endmodule

// File: rtl/jsr_stage.sv
module jsr_stage
    import jsr_pkg::*;
#(
    parameter bit ASYNC_LOAD = 1'b0
) (
    input  logic clk,
    input  op_e  op,
    input  logic shift_d,
    input  logic jam_d,
    output logic q
);

    generate
        if (ASYNC_LOAD) begin : g_async
            // The load is level-sensitive: mode and jam bit form an asynchronous set or clear.
            logic force_hi;
            logic force_lo;

            assign force_hi = (op == OP_LOAD) &&  jam_d;
            assign force_lo = (op == OP_LOAD) && !jam_d;

            always_ff @(posedge clk or posedge force_hi or posedge force_lo) begin
                if (force_lo) begin
                    q <= 1'b0;
                end else if (force_hi) begin
                    q <= 1'b1;
                end else begin
                    q <= shift_d;
                end
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                q <= (op == OP_LOAD) ? jam_d : shift_d;
            end
        end
    endgenerate

endmodule

// File: rtl/jam_shift_reg.sv
module jam_shift_reg
    import jsr_pkg::*;
#(
    parameter int STAGES     = 8,
    parameter int TAP_LO     = 6,
    parameter int TAP_MID    = 7,
    parameter bit ASYNC_LOAD = 1'b0
) (
    input  logic              clk,
    input  logic              load_ctrl,
    input  logic              ser_in,
    input  logic [STAGES-1:0] par_in,
    output logic              tap_lo,
    output logic              tap_mid,
    output logic              ser_out
);

    localparam int LAST_IDX = STAGES - 1;
    localparam int LO_IDX   = TAP_LO - 1;
    localparam int MID_IDX  = TAP_MID - 1;

    op_e               op;
    logic [STAGES-1:0] stage_q;

    jsr_mode_decode u_decode (
        .load_ctrl (load_ctrl),
        .op        (op)
    );

    // stage_q[0] sits next to the serial input; stage_q[LAST_IDX] drives the chain output.
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic d_shift;

        if (i == 0) begin : g_head
            assign d_shift = ser_in;
        end else begin : g_body
            assign d_shift = stage_q[i-1];
        end

        jsr_stage #(
            .ASYNC_LOAD (ASYNC_LOAD)
        ) u_stage (
            .clk     (clk),
            .op      (op),
            .shift_d (d_shift),
            .jam_d   (par_in[i]),
            .q       (stage_q[i])
        );
    end

    assign tap_lo  = stage_q[LO_IDX];
    assign tap_mid = stage_q[MID_IDX];
    assign ser_out = stage_q[LAST_IDX];

endmodule

// File: rtl/jsr_checker.sv
module jsr_checker #(
    parameter int STAGES     = 8,
    parameter int TAP_LO     = 6,
    parameter int TAP_MID    = 7,
    parameter bit ASYNC_LOAD = 1'b0
) (
    input logic              clk,
    input logic              load_ctrl,
    input logic [STAGES-1:0] par_in,
    input logic              tap_lo,
    input logic              tap_mid,
    input logic              ser_out
);

    // The contents are only defined after the first load.
    logic primed;
    initial primed = 1'b0;
    always @(posedge clk) begin
        if (load_ctrl) primed <= 1'b1;
    end

    logic [2:0] taps_now;
    logic [2:0] jam_view;
    assign taps_now = {ser_out, tap_mid, tap_lo};
    assign jam_view = {par_in[STAGES-1], par_in[TAP_MID-1], par_in[TAP_LO-1]};

    generate
        if (TAP_MID == TAP_LO + 1) begin : g_mid
            AST_SHIFT_INTO_MID: assert property (@(posedge clk) disable iff (!primed)
                !load_ctrl |=> (load_ctrl || tap_mid == $past(tap_lo))); // R1
        end
        if (STAGES == TAP_MID + 1) begin : g_last
            AST_SHIFT_INTO_LAST: assert property (@(posedge clk) disable iff (!primed)
                !load_ctrl |=> (load_ctrl || ser_out == $past(tap_mid))); // R1
        end
        if (STAGES == TAP_LO + 2) begin : g_two
            AST_TWO_SHIFTS: assert property (@(posedge clk) disable iff (!primed)
                !load_ctrl ##1 !load_ctrl |=> (load_ctrl || ser_out == $past(tap_lo, 2))); // R5
        end
        if (ASYNC_LOAD) begin : g_async
            AST_LEVEL_LOAD: assert property (@(posedge clk) disable iff (!primed)
                load_ctrl |-> taps_now == jam_view); // R3
        end else begin : g_sync
            AST_EDGE_LOAD: assert property (@(posedge clk) disable iff (!primed)
                load_ctrl |=> taps_now == $past(jam_view)); // R2
        end
    endgenerate

endmodule

bind jam_shift_reg jsr_checker #(
    .STAGES     (STAGES),
    .TAP_LO     (TAP_LO),
    .TAP_MID    (TAP_MID),
    .ASYNC_LOAD (ASYNC_LOAD)
) u_chk (
    .clk       (clk),
    .load_ctrl (load_ctrl),
    .par_in    (par_in),
    .tap_lo    (tap_lo),
    .tap_mid   (tap_mid),
    .ser_out   (ser_out)
);

// File: tb/jam_shift_reg_tb_top.sv
module jam_shift_reg_tb_top;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       ctrl   = 1'b0;
    logic       ser    = 1'b0;
    logic [7:0] par    = 8'h00;
    logic [7:0] par_hi = 8'h00;

    logic s_lo, s_mid, s_out;
    logic h_lo, h_mid, h_out;
    logic a_lo, a_mid, a_out;

    jam_shift_reg #(.ASYNC_LOAD(1'b0)) dut_i (
        .clk(clk), .load_ctrl(ctrl), .ser_in(ser), .par_in(par),
        .tap_lo(s_lo), .tap_mid(s_mid), .ser_out(s_out));

    jam_shift_reg #(.ASYNC_LOAD(1'b0)) dut_hi_i (
        .clk(clk), .load_ctrl(ctrl), .ser_in(s_out), .par_in(par_hi),
        .tap_lo(h_lo), .tap_mid(h_mid), .ser_out(h_out));

    jam_shift_reg #(.ASYNC_LOAD(1'b1)) dut_async_i (
        .clk(clk), .load_ctrl(ctrl), .ser_in(ser), .par_in(par),
        .tap_lo(a_lo), .tap_mid(a_mid), .ser_out(a_out));

    // Reference model: bit queues, index 0 is stage 1.
    bit qs[$];
    bit qh[$];
    bit qa[$];
    int n_chk = 0;
    int n_err = 0;
    bit primed = 1'b0;
    bit done = 1'b0;

    function automatic logic [2:0] taps(bit q[$]);
        return {logic'(q[7]), logic'(q[6]), logic'(q[5])};
    endfunction

    task automatic fill(ref bit q[$], input logic [7:0] p);
        q.delete();
        for (int i = 0; i < 8; i++) q.push_back(p[i]);
    endtask

    task automatic push(ref bit q[$], input bit b);
        q.push_front(b);
        void'(q.pop_back());
    endtask

    task automatic check(input string req, input string who, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: taps{out,mid,lo} actual=%b expected=%b at %0t", req, who, act, exp, $time);
        end
    endtask

    task automatic cyc(input string tag, input logic c, input logic s,
                       input logic [7:0] p, input logic [7:0] ph, input bit wiggle);
        logic [7:0] pf;
        bit carry;
        @(negedge clk);
        ctrl = c; ser = s; par = p; par_hi = ph;
        pf = p;
        #1;
        if (primed) begin
            check("R6", "edge", {s_out, s_mid, s_lo}, taps(qs));
            check("R6", "chain", {h_out, h_mid, h_lo}, taps(qh));
        end
        if (c) begin
            fill(qa, p);
            check("R3", "level", {a_out, a_mid, a_lo}, taps(qa));
        end else if (primed) begin
            check("R6", "level", {a_out, a_mid, a_lo}, taps(qa));
        end
        if (wiggle) begin
            #4;
            pf = ~p;
            par = pf;
            #1;
            if (c) begin
                fill(qa, pf);
                check("R3", "level-midcycle", {a_out, a_mid, a_lo}, taps(qa));
            end
            if (primed) check("R6", "edge-midcycle", {s_out, s_mid, s_lo}, taps(qs));
        end
        @(posedge clk);
        #1;
        carry = qs[7];
        if (c) begin
            fill(qs, pf);
            fill(qh, ph);
            primed = 1'b1;
        end else begin
            push(qs, s);
            push(qh, carry);
            push(qa, s);
        end
        if (primed) begin
            check(tag, "edge", {s_out, s_mid, s_lo}, taps(qs));
            check(tag, "chain", {h_out, h_mid, h_lo}, taps(qh));
            check(tag, "level", {a_out, a_mid, a_lo}, taps(qa));
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [15:0] word;
        for (int i = 0; i < 8; i++) begin
            qs.push_back(1'b0); qh.push_back(1'b0); qa.push_back(1'b0);
        end
        // R2: first load defines the contents, stands in for a reset state
        cyc("R2", 1'b1, 1'b0, 8'hA5, 8'h3C, 1'b0);
        // R4: jam bits leave ser_out from bit 7 downwards
        for (int i = 0; i < 8; i++) cyc("R4", 1'b0, 1'b0, 8'hFF, 8'h00, 1'b0);
        // R5: a pattern that tells stage 6 from stage 7 and 8
        cyc("R5", 1'b1, 1'b0, 8'b0110_0000, 8'b1010_0000, 1'b0);
        cyc("R5", 1'b0, 1'b1, 8'h00, 8'h00, 1'b0);
        // R7: carry a 16-bit word through the chained pair
        cyc("R7", 1'b1, 1'b0, 8'hC3, 8'h5A, 1'b0);
        word = 16'hB61D;
        for (int i = 0; i < 16; i++) cyc("R7", 1'b0, word[i], 8'h00, 8'h00, 1'b0);
        // R9: serial input held high during loads
        cyc("R9", 1'b1, 1'b1, 8'h00, 8'h00, 1'b0);
        cyc("R9", 1'b1, 1'b1, 8'h12, 8'h81, 1'b0);
        // R3: level load held with mid-cycle jam changes
        cyc("R3", 1'b1, 1'b0, 8'hE4, 8'h0F, 1'b1);
        cyc("R3", 1'b1, 1'b1, 8'h39, 8'hF0, 1'b1);
        // R8: first edge after release shifts
        cyc("R8", 1'b0, 1'b1, 8'hFF, 8'hFF, 1'b0);
        cyc("R8", 1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
        // R1: mixed traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc("R1", lfsr[3:0] == 4'h5, lfsr[7], lfsr[15:8], lfsr[7:0], lfsr[2]);
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule